// File: doc/BRIEF.md
# External Interrupt Pin Sense Unit

This unit watches one external interrupt pin and turns it into an interrupt request for the processor core. A 2-bit sense field selects what counts as an event on the pin: a low level, a falling edge or a rising edge. A fourth code disables triggering. The level seen by the unit is the pad value, unless the port drives the pin as an output. In that case the driven value is used, so software can raise an interrupt by writing the pin. The pin passes through a two-flop synchronizer and a one-flop history stage before edge detection.

An edge event latches a pending flag. The flag is handled by a two-state machine with states FLAG_IDLE and FLAG_PENDING. Its transitions are:

- SET: FLAG_IDLE to FLAG_PENDING on a qualified edge.
- CLEAR: FLAG_PENDING to FLAG_IDLE on acknowledge, a write-one-to-clear, or any change of the sense field.
- HOLD: every other cycle leaves the state unchanged.

In low-level mode nothing is latched: the request follows the synchronized pin. The request reaches the core only when the global interrupt-enable input and the source mask input are both high. The control register also stores a sleep-enable bit and a sleep-mode bit (0 selects idle, 1 selects power-down). These two bits are only stored and brought out on outputs.

Top module: `extint_sense_unit`

## Requirements
- R1: After reset, the control register reads 0x00, the pending flag reads 0 and `irq_req_o` is 0. The synchronizer stages reset to a high level.
- R2: Register select 0 is the control register. The sense field is bits 1:0, sleep-mode is bit 4 and sleep-enable is bit 5. Bits 7, 6, 3 and 2 read as zero and ignore writes.
- R3: With sense 00 (low level), the request is high exactly while the twice-synchronized pin is low. It rises two clocks after the pin goes low, falls two clocks after the pin goes high, and nothing is latched.
- R4: With sense 10 (falling edge), a high-to-low pin transition sets the pending flag. The flag and the gated request become visible three clock edges after the pin changes, and they stay set after the pin returns high.
- R5: With sense 11 (rising edge), a low-to-high pin transition sets the pending flag, with the same three-edge timing as R4.
- R6: With sense 01, no pin activity sets the flag or raises the request.
- R7: `irq_req_o` is high only when `global_ie_i` and `src_mask_i` are both 1. The pending flag still sets while either of them is 0.
- R8: The pending flag clears on `irq_ack_i`. It also clears on a write to register select 1 with bit 0 set. A write of 0 to that bit has no effect. Register select 1 reads the flag in bit 0 and zeros elsewhere.
- R9: If a new qualified edge and an acknowledge or write-one-to-clear fall in the same cycle, the flag ends set.
- R10: A control write whose sense field differs from the stored one clears the pending flag, even if an edge is detected in that cycle. A control write with an unchanged sense field leaves the flag alone.
- R11: When `pin_drive_en_i` is 1, the value on `pin_drive_val_i` replaces the pad value as the sensed level, and it triggers like a pad level.
- R12: `sleep_en_o` and `sleep_pd_o` reflect control bits 5 and 4 one cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_pad_i | input | 1 | Pad level of the interrupt pin |
| pin_drive_en_i | input | 1 | Port drives the pin as an output |
| pin_drive_val_i | input | 1 | Value driven when the pin is an output |
| reg_sel_i | input | 1 | Register select: 0 control, 1 pending flag |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for the selected register |
| global_ie_i | input | 1 | Global interrupt-enable flag |
| src_mask_i | input | 1 | Mask bit for this source |
| irq_ack_i | input | 1 | Core acknowledges this interrupt |
| irq_req_o | output | 1 | Gated interrupt request |
| sleep_en_o | output | 1 | Stored sleep-enable bit |
| sleep_pd_o | output | 1 | Stored sleep-mode bit (1 = power-down) |

## Verification
The set path of the flag can coincide with two clear paths: an acknowledge or a write-one-to-clear, and a reconfiguration of the sense field. The bench drives the pin so that the edge is detected in a known cycle. It then asserts the acknowledge, the clearing write, or a control write with a new sense code in exactly that cycle. The result is judged by reading the flag register and the request on the next cycle: set wins over acknowledge and write-one-to-clear, and reconfiguration wins over set. A cycle-accurate reference model checks the same outcome on every clock.

// File: rtl/extint_pkg.sv
package extint_pkg;

    localparam int REG_W      = 8;
    localparam int SENSE_LSB  = 0;
    localparam int SLEEP_PD_B = 4;
    localparam int SLEEP_EN_B = 5;
    localparam int FLAG_BIT   = 0;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_NONE = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    typedef enum logic {
        FLAG_IDLE    = 1'b0,
        FLAG_PENDING = 1'b1
    } flag_state_e;

    typedef struct packed {
        logic   sleep_en;
        logic   sleep_pd;
        sense_e sense;
    } ctrl_t;

endpackage

// File: rtl/extint_pin_sync.sv
module extint_pin_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o,
    output logic fall_o,
    output logic rise_o
);

    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;
    logic          hist_q;

    generate
        if (STAGES < 2) begin : g_bad_depth
            initial $error("extint_pin_sync needs at least two stages");
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_LVL}};
            hist_q  <= RST_LVL;
        end else begin
            chain_q <= {chain_q[LAST-1:0], pin_i};
            hist_q  <= chain_q[LAST];
        end
    end

    always_comb begin
        level_o = chain_q[LAST];
        fall_o  = hist_q & ~chain_q[LAST];
        rise_o  = ~hist_q & chain_q[LAST];
    end

endmodule

// File: rtl/extint_ctrl_reg.sv
module extint_ctrl_reg
    import extint_pkg::*;
#(
    parameter int DATA_W = REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output ctrl_t             ctrl_o,
    output logic              sense_change_o,
    output logic [DATA_W-1:0] rdata_o
);

    ctrl_t  ctrl_q;
    sense_e wr_sense;

    always_comb begin
        wr_sense       = sense_e'(wdata_i[SENSE_LSB +: 2]);
        sense_change_o = wr_i && (wr_sense != ctrl_q.sense);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '{sleep_en: 1'b0, sleep_pd: 1'b0, sense: SENSE_LOW};
        end else if (wr_i) begin
            ctrl_q.sense    <= wr_sense;
            ctrl_q.sleep_pd <= wdata_i[SLEEP_PD_B];
            ctrl_q.sleep_en <= wdata_i[SLEEP_EN_B];
        end
    end

    always_comb begin
        rdata_o                   = '0;
        rdata_o[SENSE_LSB +: 2]   = ctrl_q.sense;
        rdata_o[SLEEP_PD_B]       = ctrl_q.sleep_pd;
        rdata_o[SLEEP_EN_B]       = ctrl_q.sleep_en;
        ctrl_o                    = ctrl_q;
    end

endmodule

// File: rtl/extint_flag_fsm.sv
module extint_flag_fsm
    import extint_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  sense_e sense_i,
    input  logic   fall_i,
    input  logic   rise_i,
    input  logic   ack_i,
    input  logic   w1c_i,
    input  logic   sense_change_i,
    output logic   pending_o
);

    flag_state_e state_q;
    flag_state_e state_d;
    logic        edge_hit;
    logic        clear_req;

    always_comb begin
        unique case (sense_i)
            SENSE_FALL: edge_hit = fall_i;
            SENSE_RISE: edge_hit = rise_i;
            SENSE_LOW:  edge_hit = 1'b0;
            SENSE_NONE: edge_hit = 1'b0;
            default:    edge_hit = 1'b0;
        endcase
        clear_req = ack_i | w1c_i;
    end

    // Next state: reconfiguration beats a new edge, a new edge beats ack/W1C.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: begin
                if (edge_hit && !sense_change_i) begin
                    state_d = FLAG_PENDING;
                end
            end
            FLAG_PENDING: begin
                if (sense_change_i) begin
                    state_d = FLAG_IDLE;
                end else if (edge_hit) begin
                    state_d = FLAG_PENDING;
                end else if (clear_req) begin
                    state_d = FLAG_IDLE;
                end
            end
            default: state_d = FLAG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FLAG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            FLAG_PENDING: pending_o = 1'b1;
            FLAG_IDLE:    pending_o = 1'b0;
            default:      pending_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/extint_sense_unit.sv
module extint_sense_unit
    import extint_pkg::*;
#(
    parameter int DATA_W      = REG_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_pad_i,
    input  logic              pin_drive_en_i,
    input  logic              pin_drive_val_i,
    input  logic              reg_sel_i,
    input  logic              reg_wr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    input  logic              global_ie_i,
    input  logic              src_mask_i,
    input  logic              irq_ack_i,
    output logic              irq_req_o,
    output logic              sleep_en_o,
    output logic              sleep_pd_o
);

    logic              pin_eff;
    logic              sync_lvl;
    logic              sync_fall;
    logic              sync_rise;
    logic              wr_ctrl;
    logic              wr_flag_clr;
    logic              sense_change;
    logic              pending;
    logic              raw_req;
    logic [DATA_W-1:0] ctrl_rdata;
    ctrl_t             ctrl;

    always_comb begin
        pin_eff     = pin_drive_en_i ? pin_drive_val_i : pin_pad_i;
        wr_ctrl     = reg_wr_i && !reg_sel_i;
        wr_flag_clr = reg_wr_i && reg_sel_i && reg_wdata_i[FLAG_BIT];
    end

    extint_pin_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_LVL (1'b1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (pin_eff),
        .level_o (sync_lvl),
        .fall_o  (sync_fall),
        .rise_o  (sync_rise)
    );

    extint_ctrl_reg #(
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_i           (wr_ctrl),
        .wdata_i        (reg_wdata_i),
        .ctrl_o         (ctrl),
        .sense_change_o (sense_change),
        .rdata_o        (ctrl_rdata)
    );

    extint_flag_fsm u_flag (
        .clk            (clk),
        .rst_n          (rst_n),
        .sense_i        (ctrl.sense),
        .fall_i         (sync_fall),
        .rise_i         (sync_rise),
        .ack_i          (irq_ack_i),
        .w1c_i          (wr_flag_clr),
        .sense_change_i (sense_change),
        .pending_o      (pending)
    );

    always_comb begin
        unique case (ctrl.sense)
            SENSE_LOW:  raw_req = ~sync_lvl;
            SENSE_NONE: raw_req = 1'b0;
            SENSE_FALL: raw_req = pending;
            SENSE_RISE: raw_req = pending;
            default:    raw_req = 1'b0;
        endcase
        irq_req_o = raw_req & global_ie_i & src_mask_i;
    end

    always_comb begin
        if (reg_sel_i) begin
            reg_rdata_o           = '0;
            reg_rdata_o[FLAG_BIT] = pending;
        end else begin
            reg_rdata_o = ctrl_rdata;
        end
        sleep_en_o = ctrl.sleep_en;
        sleep_pd_o = ctrl.sleep_pd;
    end

endmodule

// File: rtl/extint_sense_chk.sv
module extint_sense_chk
    import extint_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       reg_sel_i,
    input logic [7:0] reg_rdata_o,
    input logic       global_ie_i,
    input logic       src_mask_i,
    input logic       irq_req_o,
    input logic       irq_ack_i,
    input logic       sense_change,
    input sense_e     sense,
    input logic       pending,
    input logic       sync_fall,
    input logic       sync_rise
);

    logic qual_edge;
    assign qual_edge = (sense == SENSE_FALL && sync_fall) || (sense == SENSE_RISE && sync_rise);

    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_sel_i |-> (reg_rdata_o[7:6] == 2'b00 && reg_rdata_o[3:2] == 2'b00));

    p_none_mode_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sense == SENSE_NONE && !pending) |=> !pending);

    p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(global_ie_i && src_mask_i) |-> !irq_req_o);

    p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack_i && !qual_edge) |=> !pending);

    p_edge_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (qual_edge && !sense_change) |=> pending);

    p_reconfig_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sense_change |=> !pending);

endmodule

bind extint_sense_unit extint_sense_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_sel_i    (reg_sel_i),
    .reg_rdata_o  (reg_rdata_o[7:0]),
    .global_ie_i  (global_ie_i),
    .src_mask_i   (src_mask_i),
    .irq_req_o    (irq_req_o),
    .irq_ack_i    (irq_ack_i),
    .sense_change (sense_change),
    .sense        (ctrl.sense),
    .pending      (pending),
    .sync_fall    (sync_fall),
    .sync_rise    (sync_rise)
);

// File: tb/extint_sense_unit_tb.sv
module extint_sense_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       pin_pad, drv_en, drv_val, sel, wr, ie, mask, ack;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       irq, slp_en, slp_pd;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    extint_sense_unit dut_i (
        .clk(clk), .rst_n(rst_n), .pin_pad_i(pin_pad), .pin_drive_en_i(drv_en),
        .pin_drive_val_i(drv_val), .reg_sel_i(sel), .reg_wr_i(wr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .global_ie_i(ie), .src_mask_i(mask), .irq_ack_i(ack),
        .irq_req_o(irq), .sleep_en_o(slp_en), .sleep_pd_o(slp_pd)
    );

    // Reference model: pin history queue, [0]=newest sample, [1]=synced level, [2]=previous
    int m_hist[$];
    int m_sense, m_se, m_sm, m_flag;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_hist = '{1, 1, 1};
            m_sense = 0; m_se = 0; m_sm = 0; m_flag = 0;
        end else begin
            int eff, fell, rose, hit;
            bit chg, clr;
            eff  = drv_en ? int'(drv_val) : int'(pin_pad);
            fell = (m_hist[2] == 1 && m_hist[1] == 0);
            rose = (m_hist[2] == 0 && m_hist[1] == 1);
            hit  = (m_sense == 2 && fell) || (m_sense == 3 && rose);
            chg  = wr && !sel && (int'(wdata[1:0]) != m_sense);
            clr  = ack || (wr && sel && wdata[0]);
            if (chg) m_flag = 0;
            else if (hit) m_flag = 1;
            else if (clr) m_flag = 0;
            if (wr && !sel) begin
                m_sense = int'(wdata[1:0]);
                m_sm = int'(wdata[4]);
                m_se = int'(wdata[5]);
            end
            m_hist.push_front(eff);
            void'(m_hist.pop_back());
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison, away from both clock edges
    always begin
        @(negedge clk);
        #3;
        if (rst_n && m_hist.size() == 3) begin
            int exp_req, exp_rd;
            exp_req = (ie && mask) ? ((m_sense == 0) ? int'(m_hist[1] == 0)
                                      : (m_sense == 1) ? 0 : m_flag) : 0;
            exp_rd = sel ? m_flag : (m_se * 32 + m_sm * 16 + m_sense);
            chk("model R7 irq_req", int'(irq), exp_req);
            chk("model R2 rdata", int'(rdata), exp_rd);
            chk("model R12 sleep", int'({slp_en, slp_pd}), m_se * 2 + m_sm);
        end
    end

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_reg(input logic s, input logic [7:0] d);
        sel = s; wdata = d; wr = 1'b1;
        tick();
        wr = 1'b0; wdata = 8'h00;
    endtask

    task automatic rd_flag(input string tag, input int exp);
        sel = 1'b1; #1;
        chk(tag, int'(rdata), exp);
        sel = 1'b0;
    endtask

    initial begin
        #2000000;
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; pin_pad = 1; drv_en = 0; drv_val = 1; sel = 0; wr = 0;
        wdata = 0; ie = 0; mask = 0; ack = 0;
        tick(3);
        rst_n = 1;
        tick();
        #1;
        chk("R1 ctrl reset", int'(rdata), 0);
        chk("R1 irq reset", int'(irq), 0);
        rd_flag("R1 flag reset", 0);

        // R2 and R12: layout, reserved bits
        wr_reg(0, 8'hFF); #1;
        chk("R2 reserved read zero", int'(rdata), 8'h33);
        chk("R12 sleep outputs", int'({slp_en, slp_pd}), 3);
        wr_reg(0, 8'h10); #1;
        chk("R12 power-down only", int'({slp_en, slp_pd}), 1);
        wr_reg(0, 8'h00);

        // R3 level mode
        ie = 1; mask = 1;
        pin_pad = 0; tick(); #1;
        chk("R3 not yet after one edge", int'(irq), 0);
        tick(); #1;
        chk("R3 level request", int'(irq), 1);
        pin_pad = 1; tick(2); #1;
        chk("R3 released, no latch", int'(irq), 0);
        rd_flag("R3 no flag in level mode", 0);

        // R4 falling edge
        wr_reg(0, 8'h02);
        pin_pad = 0; tick(2); #1;
        chk("R4 not yet", int'(irq), 0);
        tick(); #1;
        chk("R4 falling request", int'(irq), 1);
        pin_pad = 1; tick(3); #1;
        chk("R4 sticky", int'(irq), 1);
        ack = 1; tick(); ack = 0; #1;
        chk("R8 ack clears", int'(irq), 0);

        // R5 rising edge, R8 write-one-to-clear
        wr_reg(0, 8'h03);
        pin_pad = 0; tick(4);
        rd_flag("R5 falling ignored in rise mode", 0);
        pin_pad = 1; tick(3); #1;
        chk("R5 rising request", int'(irq), 1);
        wr_reg(1, 8'hFE);
        rd_flag("R8 write zero keeps flag", 1);
        wr_reg(1, 8'h01);
        rd_flag("R8 write one clears", 0);

        // R6 reserved sense code
        wr_reg(0, 8'h01);
        pin_pad = 0; tick(4); pin_pad = 1; tick(4); #1;
        chk("R6 no request", int'(irq), 0);
        rd_flag("R6 no flag", 0);

        // R7 gating
        wr_reg(0, 8'h02);
        mask = 0;
        pin_pad = 0; tick(4); #1;
        chk("R7 masked request", int'(irq), 0);
        rd_flag("R7 flag still set", 1);
        mask = 1; ie = 0; #1;
        chk("R7 global off", int'(irq), 0);
        ie = 1; #1;
        chk("R7 both on", int'(irq), 1);
        pin_pad = 1; tick(3);
        wr_reg(1, 8'h01);

        // R11 output-driven pin
        drv_en = 1; drv_val = 0; tick(4); #1;
        chk("R11 driven low triggers", int'(irq), 1);
        drv_val = 1; tick(3);
        wr_reg(1, 8'h01);
        drv_en = 0; tick(3);

        // R9 new edge coincides with ack (flag already pending)
        pin_pad = 0; tick(4); pin_pad = 1; tick(3);
        rd_flag("R9 pre-pending", 1);
        pin_pad = 0; tick(2);
        ack = 1; tick(); ack = 0;
        rd_flag("R9 edge beats ack", 1);
        pin_pad = 1; tick(3);
        // R9 new edge coincides with write-one-to-clear
        pin_pad = 0; tick(2);
        wr_reg(1, 8'h01);
        rd_flag("R9 edge beats W1C", 1);
        pin_pad = 1; tick(3);

        // R10 unchanged sense keeps flag, changed sense clears even with edge
        wr_reg(0, 8'h22);
        rd_flag("R10 same sense keeps flag", 1);
        pin_pad = 0; tick(2);
        wr_reg(0, 8'h03);
        rd_flag("R10 reconfig beats edge", 0);
        #1;
        chk("R10 request dropped", int'(irq), 0);
        pin_pad = 1; tick(5);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule